// File: doc/BRIEF.md
# Two-Row Button Matrix Scan Port

This block is an 8-bit port register that scans a matrix of eight buttons arranged as two rows of four columns. Software writes the register to choose which of the two rows take part in the scan. A row select bit is active low: writing 0 enables that row and writing 1 disables it. Reading the register returns four active-low column bits. A column bit is pulled to 0 when an enabled row has the button in that column pressed.

The button inputs arrive already debounced and active high, with 1 meaning pressed. Each write updates both row-select latches at the same time. The read value is formed combinationally from the latches and the live button levels, so a button change shows on the read data without waiting for a clock edge. The upper nibble of the read data is always 1s. A scan routine usually enables one row, reads the columns, then enables the other row and reads again. Enabling both rows gives a quick "any button in this column" test.

Top module: `keypad_scan_port`

## Requirements
- R1: While reset is asserted, and after reset until the first write, no row is enabled and the read data is 0xFF whatever the buttons are doing.
- R2: A write with data bit 4 = 0 enables row A (button inputs `btn_a`), and a write with bit 4 = 1 disables it. The new setting is visible on the read data from the cycle after the write edge.
- R3: A write with data bit 5 = 0 enables row B (button inputs `btn_b`), and a write with bit 5 = 1 disables it. The new setting is visible from the cycle after the write edge.
- R4: Read bit k (k = 0..3) belongs to column k. It reads 0 only when an enabled row has button k pressed. A released button, or a button in a disabled row, gives 1.
- R5: When both rows are enabled, read bit k is 0 if button k of either row is pressed.
- R6: Read bits 7 down to 4 are always 1.
- R7: The read data follows changes on the button inputs in the same cycle, with no clock edge in between.
- R8: Write data bits 0-3, 6 and 7 have no effect. In cycles where `wr_en` is low, the row enables hold their value whatever `wr_data` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; bit 4 selects row A, bit 5 selects row B, both active low |
| btn_a | input | 4 | Row A buttons, 1 = pressed, bit k = column k |
| btn_b | input | 4 | Row B buttons, 1 = pressed, bit k = column k |
| rd_data | output | 8 | Read data; bits 3:0 active-low columns, bits 7:4 always 1 |

## Verification
The bench walks a single pressed button across every column with only one row enabled. A design with swapped or misnumbered columns would pull the wrong bit low there. It also holds buttons in the disabled row while the other row is scanned. A design that ignores the select would leak those presses into the columns. Both-rows-enabled cases with different buttons in each row catch an AND merge in place of an OR merge. A write with all unrelated data bits set, and idle cycles with row-disabling data on the bus, expose a latch that decodes the wrong bits or loads without the strobe. Button changes checked before the next clock edge catch a read path that was registered by mistake.

// File: rtl/keypad_pkg.sv
package keypad_pkg;

    localparam int KP_DATA_W   = 8;
    localparam int KP_NUM_COLS = 4;
    localparam int KP_SEL_A    = 4;
    localparam int KP_SEL_B    = 5;

    typedef struct packed {
        logic row_b_on;
        logic row_a_on;
    } row_sel_t;

    localparam row_sel_t ROW_SEL_NONE = '{row_b_on: 1'b0, row_a_on: 1'b0};

    // Decode one write into row enables; a 0 data bit enables its row.
    function automatic row_sel_t decode_sel(input logic bit_a, input logic bit_b);
        row_sel_t s;
        s.row_a_on = ~bit_a;
        s.row_b_on = ~bit_b;
        return s;
    endfunction

    // One column: low when any enabled row has the button pressed.
    function automatic logic column_level(input row_sel_t s, input logic pa, input logic pb);
        return ~((s.row_a_on & pa) | (s.row_b_on & pb));
    endfunction

endpackage

// File: rtl/keypad_sel_latch.sv
module keypad_sel_latch
    import keypad_pkg::*;
#(
    parameter int DATA_W = KP_DATA_W,
    parameter int SEL_A  = KP_SEL_A,
    parameter int SEL_B  = KP_SEL_B
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output row_sel_t          sel_q
);

    row_sel_t sel_d;

    always_comb begin
        sel_d = sel_q;
        if (wr_en) begin
            sel_d = decode_sel(wr_data[SEL_A], wr_data[SEL_B]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= ROW_SEL_NONE;
        end else begin
            sel_q <= sel_d;
        end
    end

endmodule

// File: rtl/keypad_col_merge.sv
module keypad_col_merge
    import keypad_pkg::*;
#(
    parameter int DATA_W   = KP_DATA_W,
    parameter int NUM_COLS = KP_NUM_COLS
) (
    input  row_sel_t            sel,
    input  logic [NUM_COLS-1:0] btn_a,
    input  logic [NUM_COLS-1:0] btn_b,
    output logic [DATA_W-1:0]   rd_data
);

    localparam int PAD_W = DATA_W - NUM_COLS;

    logic [NUM_COLS-1:0] col_n;

    for (genvar k = 0; k < NUM_COLS; k++) begin : g_col
        assign col_n[k] = column_level(sel, btn_a[k], btn_b[k]);
    end

    if (PAD_W > 0) begin : g_pad
        assign rd_data = {{PAD_W{1'b1}}, col_n};
    end else begin : g_nopad
        assign rd_data = col_n[DATA_W-1:0];
    end

endmodule

// File: rtl/keypad_scan_port.sv
module keypad_scan_port
    import keypad_pkg::*;
#(
    parameter int DATA_W   = KP_DATA_W,
    parameter int NUM_COLS = KP_NUM_COLS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [NUM_COLS-1:0] btn_a,
    input  logic [NUM_COLS-1:0] btn_b,
    output logic [DATA_W-1:0]   rd_data
);

    row_sel_t   sel_q;
    logic [1:0] row_sel;

    assign row_sel = {sel_q.row_b_on, sel_q.row_a_on};

    keypad_sel_latch #(
        .DATA_W (DATA_W),
        .SEL_A  (KP_SEL_A),
        .SEL_B  (KP_SEL_B)
    ) u_latch (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .sel_q   (sel_q)
    );

    keypad_col_merge #(
        .DATA_W   (DATA_W),
        .NUM_COLS (NUM_COLS)
    ) u_merge (
        .sel     (sel_q),
        .btn_a   (btn_a),
        .btn_b   (btn_b),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/keypad_scan_port_chk.sv
module keypad_scan_port_chk #(
    parameter int DATA_W   = 8,
    parameter int NUM_COLS = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [DATA_W-1:0]   wr_data,
    input logic [NUM_COLS-1:0] btn_a,
    input logic [NUM_COLS-1:0] btn_b,
    input logic [DATA_W-1:0]   rd_data,
    input logic [1:0]          sel_q
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (rd_data == {DATA_W{1'b1}}));

    assert_row_a_only_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[4] && wr_data[5]) |=> (rd_data[NUM_COLS-1:0] == ~btn_a));

    assert_row_b_only_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[4] && !wr_data[5]) |=> (rd_data[NUM_COLS-1:0] == ~btn_b));

    assert_no_rows_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[4] && wr_data[5]) |=> (rd_data == {DATA_W{1'b1}}));

    assert_both_rows_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[4] && !wr_data[5]) |=> (rd_data[NUM_COLS-1:0] == ~(btn_a | btn_b)));

    assert_hold_sel_R8: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(sel_q));

endmodule

bind keypad_scan_port keypad_scan_port_chk #(
    .DATA_W   (DATA_W),
    .NUM_COLS (NUM_COLS)
) i_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .btn_a   (btn_a),
    .btn_b   (btn_b),
    .rd_data (rd_data),
    .sel_q   (row_sel)
);

// File: tb/test_keypad_scan_port.sv
`timescale 1ns/1ps
module test_keypad_scan_port;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [3:0] btn_a = 4'h0;
    logic [3:0] btn_b = 4'h0;
    logic [7:0] rd_data;

    always #2.5 clk = ~clk;

    keypad_scan_port i_keypad_scan_port (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .btn_a(btn_a), .btn_b(btn_b), .rd_data(rd_data)
    );

    typedef struct {
        logic [7:0] exp;
        logic [7:0] msk;
        string      tag;
    } item_t;

    item_t q[$];
    int total = 0;
    int bad = 0;
    bit done = 0;
    bit m_a = 0;
    bit m_b = 0;
    bit m_rst = 1;

    function automatic logic [7:0] model();
        logic [3:0] c;
        c = 4'h0;
        if (!m_rst) begin
            if (m_a) c = c | btn_a;
            if (m_b) c = c | btn_b;
        end
        return {4'hF, ~c};
    endfunction

    task automatic push(input string tag, input logic [7:0] msk = 8'hFF);
        item_t it;
        it.exp = model();
        it.msk = msk;
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic wr(input logic [7:0] v);
        @(posedge clk); #1;
        wr_en = 1'b1;
        wr_data = v;
        @(posedge clk); #1;
        wr_en = 1'b0;
        m_a = ~v[4];
        m_b = ~v[5];
    endtask

    task automatic step(input logic [3:0] a, input logic [3:0] b, input string tag);
        @(posedge clk); #1;
        btn_a = a;
        btn_b = b;
        push(tag);
    endtask

    // Monitor: compare queued expectations mid-cycle.
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                total++;
                if ((rd_data & it.msk) !== (it.exp & it.msk)) begin
                    bad++;
                    $display("FAIL %s: rd_data=%02h expected=%02h (mask %02h)",
                             it.tag, rd_data, it.exp, it.msk);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset with buttons pressed
        btn_a = 4'hF; btn_b = 4'hF;
        repeat (3) @(posedge clk);
        #1; push("R1 during reset");
        @(posedge clk); #1;
        rst = 1'b0; m_rst = 0;
        step(4'hF, 4'hF, "R1 after reset, no write");

        // R2/R4: row A only, walk columns; row B pressed must not leak
        wr(8'h20);
        for (int k = 0; k < 4; k++) begin
            step(4'(1 << k), 4'hF, "R4 single column row A");
        end
        step(4'h5, 4'hA, "R2 row A pattern 5");
        step(4'hA, 4'h5, "R2 row A pattern A");
        step(4'h0, 4'hF, "R2 row A released");
        @(posedge clk); #1; push("R6 upper nibble", 8'hF0);

        // R7: button change seen without a clock edge
        @(posedge clk); #1;
        btn_a = 4'h2;
        push("R7 same-cycle button change");

        // R3/R4: row B only
        wr(8'h10);
        for (int k = 0; k < 4; k++) begin
            step(4'hF, 4'(1 << k), "R4 single column row B");
        end
        step(4'hF, 4'h9, "R3 row B pattern 9");

        // R5: both rows
        wr(8'h00);
        step(4'h1, 4'h8, "R5 both rows disjoint");
        step(4'h3, 4'h6, "R5 both rows overlap");
        step(4'h0, 4'h0, "R5 both rows released");

        // R2/R3: deselect both
        wr(8'h30);
        step(4'hF, 4'hF, "R2 deselected rows");

        // R8: junk bits ignored, hold when not writing
        wr(8'hCF);
        step(4'h1, 4'h2, "R8 unrelated bits ignored");
        @(posedge clk); #1;
        wr_data = 8'h30;
        repeat (3) @(posedge clk);
        step(4'h4, 4'h8, "R8 hold without strobe");
        @(posedge clk); #1; push("R6 upper nibble both rows", 8'hF0);

        // R1: reset while rows enabled
        @(posedge clk); #1;
        rst = 1'b1;
        @(posedge clk); #1;
        m_rst = 1; m_a = 0; m_b = 0;
        push("R1 reset clears rows");
        @(posedge clk); #1;
        rst = 1'b0; m_rst = 0;
        step(4'hF, 4'hF, "R1 idle after mid-run reset");

        repeat (2) @(posedge clk);
        wait (q.size() == 0);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule